// File: doc/BRIEF.md
# Absolute-addressing bus cycle sequencer

This block controls the bus cycles of a small 8-bit accumulator processor with a 16-bit address bus. It runs only instructions that carry a full two-byte operand address. Each instruction fetches its opcode, then the low and then the high address byte. On the fourth cycle it reads or writes the byte at the assembled address. The block drives the address, a read/write strobe and a flag that marks opcode fetches. It keeps the operand address in a private register that no instruction can reach.

Instructions that read memory (load and the four accumulator operations) finish their accumulator update during the clock that fetches the next opcode. That clock is the only overlap between two instructions. A store puts the accumulator on the write bus during its fourth cycle and then fetches the next opcode in a fifth cycle. The block has no prefetch or instruction buffer, so every byte comes from memory as it is at that moment. This makes self-modifying programs behave correctly. An opcode outside the supported set stops the sequencer, and it stays stopped until reset.

Top module: `abs_bus_seq`

## Requirements
- R1: While reset is high at a rising edge, the program counter loads from `reset_vec`. The first cycle after reset is an opcode fetch at that address with `sync`=1, `rw`=1 and `halt`=0. The accumulator and carry clear to 0.
- R2: The fetch cycle is followed by a read at PC+1 and then a read at PC+2. Both reads have `sync`=0 and `rw`=1. The first of these two bytes is the low address byte.
- R3: The fourth cycle drives the address {byte read at PC+2, byte read at PC+1}.
- R4: For read-type instructions, `rw` is 1 in all four cycles. The next opcode fetch happens in the cycle right after, at PC+3.
- R5: For a store, `rw` is 0 only in the fourth cycle, and `wdata` then carries the accumulator. The next fetch is in cycle five at PC+3.
- R6: A read-type instruction updates the accumulator during the following opcode-fetch cycle. A store placed directly after it writes the updated value.
- R7: Load copies the operand. Add computes acc+operand+carry and keeps the carry-out as the new carry. AND, OR and XOR combine acc with the operand bitwise and leave the carry unchanged.
- R8: No bytes are buffered. A byte that a store modified is fetched with its new value when the program reaches it.
- R9: Any other opcode is fetched normally. From the next cycle on, `halt`=1, `sync`=0, `rw`=1 and the address holds the illegal opcode's address until reset.
- R10: Opcode encodings: load 0xAD, store 0x8D, add 0x6D, AND 0x2D, OR 0x0D, XOR 0x4D.
- R11: Program-counter arithmetic wraps modulo 2^16. A fetch at 0xFFFE reads address bytes at 0xFFFF and then 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | 16 | Start address loaded into PC on reset |
| rdata | input | 8 | Read data from memory |
| addr | output | 16 | Address of the current bus cycle |
| rw | output | 1 | 1 = read cycle, 0 = write cycle |
| sync | output | 1 | High during opcode-fetch cycles |
| wdata | output | 8 | Write data (accumulator) |
| halt | output | 1 | High once an illegal opcode has been fetched |

## Verification
The bench pre-computes the address, strobe, sync and halt value of every cycle and compares each one, covering back-to-back loads, ALU operations and stores. A design that swapped the two address bytes would emit a byte-reversed fourth-cycle address. A design that applied the result late, or dropped the overlap update, would store a stale accumulator. A design that buffered instruction bytes would miss the store that rewrites a later instruction's address byte and would read the wrong operand. Other cases covered are the add carry chain across two instructions, program-counter wrap at the top of memory, and the halt that an illegal opcode must cause without any further writes.

// File: rtl/abs_bus_seq.sv
module abs_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [DW-1:0] OP_LOAD  = 8'hAD,
  parameter logic [DW-1:0] OP_STORE = 8'h8D,
  parameter logic [DW-1:0] OP_ADD   = 8'h6D,
  parameter logic [DW-1:0] OP_AND   = 8'h2D,
  parameter logic [DW-1:0] OP_OR    = 8'h0D,
  parameter logic [DW-1:0] OP_XOR   = 8'h4D
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vec,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic          rw,
  output logic          sync,
  output logic [DW-1:0] wdata,
  output logic          halt
);
  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_FETCH, S_ALO, S_AHI, S_EXEC, S_HALT} st_t;
  typedef enum logic [2:0] {K_LOAD, K_STORE, K_ADD, K_AND, K_OR, K_XOR, K_BAD} kind_t;

  st_t           st;
  kind_t         kind, dec;
  logic [AW-1:0] pc, ea;
  logic [DW-1:0] acc, opnd, res;
  logic          cy, res_cy, pend;
  logic [DW:0]   sum;

  always_comb begin
    unique case (rdata)
      OP_LOAD:  dec = K_LOAD;
      OP_STORE: dec = K_STORE;
      OP_ADD:   dec = K_ADD;
      OP_AND:   dec = K_AND;
      OP_OR:    dec = K_OR;
      OP_XOR:   dec = K_XOR;
      default:  dec = K_BAD;
    endcase
  end

  assign sum = {1'b0, acc} + {1'b0, opnd} + {{DW{1'b0}}, cy};

  always_comb begin
    res    = acc;
    res_cy = cy;
    case (kind)
      K_LOAD: res = opnd;
      K_ADD:  begin res = sum[DW-1:0]; res_cy = sum[DW]; end
      K_AND:  res = acc & opnd;
      K_OR:   res = acc | opnd;
      K_XOR:  res = acc ^ opnd;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_FETCH;
      pc   <= reset_vec;
      ea   <= '0;
      acc  <= '0;
      cy   <= 1'b0;
      opnd <= '0;
      pend <= 1'b0;
      kind <= K_BAD;
    end else begin
      case (st)
        S_FETCH: begin
          kind <= dec;
          st   <= (dec == K_BAD) ? S_HALT : S_ALO;
          if (pend) begin
            acc  <= res;
            cy   <= res_cy;
            pend <= 1'b0;
          end
        end
        S_ALO: begin
          ea[DW-1:0] <= rdata;
          st <= S_AHI;
        end
        S_AHI: begin
          ea[AW-1:DW] <= rdata[HW-1:0];
          st <= S_EXEC;
        end
        S_EXEC: begin
          pc <= pc + AW'(3);
          st <= S_FETCH;
          if (kind != K_STORE) begin
            opnd <= rdata;
            pend <= 1'b1;
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_ALO:   addr = pc + AW'(1);
      S_AHI:   addr = pc + AW'(2);
      S_EXEC:  addr = ea;
      default: addr = pc;
    endcase
  end

  assign rw    = !(st == S_EXEC && kind == K_STORE);
  assign sync  = (st == S_FETCH);
  assign halt  = (st == S_HALT);
  assign wdata = acc;
endmodule

// File: rtl/abs_bus_seq_chk.sv
module abs_bus_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          rw,
  input logic          sync,
  input logic          halt
);
  a_r1_reset_fetch: assert property (@(posedge clk) rst |=> (sync && rw && !halt));

  a_r2_low_byte_next: assert property (@(posedge clk) disable iff (rst)
    (sync && !halt) |=> (halt || (addr == $past(addr) + AW'(1) && !sync && rw)));

  a_r5_write_then_fetch: assert property (@(posedge clk) disable iff (rst)
    !rw |=> (sync && rw));

  a_r5_write_not_fetch: assert property (@(posedge clk) disable iff (rst)
    !rw |-> (!sync && !halt));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && rw && !sync && $stable(addr)));

  a_r9_halt_after_fetch: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> $past(sync));
endmodule

bind abs_bus_seq abs_bus_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rw(rw), .sync(sync), .halt(halt)
);

// File: tb/tb_abs_bus_seq.sv
module tb_abs_bus_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reset_vec = 16'h0100;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        rw, sync, halt;
  logic [7:0]  wdata;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [15:0] a;
    logic        r;
    logic        s;
    logic        h;
    logic [7:0]  d;
    string       tag;
  } item_t;

  item_t q[$];
  logic [7:0] mem [0:4095];

  always #2 clk = ~clk;

  abs_bus_seq dut (
    .clk(clk), .rst(rst), .reset_vec(reset_vec), .rdata(rdata),
    .addr(addr), .rw(rw), .sync(sync), .wdata(wdata), .halt(halt)
  );

  assign rdata = mem[addr[11:0]];

  always @(posedge clk) if (!rst && !rw) mem[addr[11:0]] <= wdata;

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (addr !== e.a || rw !== e.r || sync !== e.s || halt !== e.h ||
          (!e.r && wdata !== e.d)) begin
        failures++;
        $display("FAIL %s: addr=%h rw=%b sync=%b halt=%b wdata=%h expected addr=%h rw=%b sync=%b halt=%b wdata=%h",
                 e.tag, addr, rw, sync, halt, wdata, e.a, e.r, e.s, e.h, e.d);
      end
    end
  end

  task automatic push(input logic [15:0] a, input logic r, input logic s,
                      input logic h, input logic [7:0] d, input string tag);
    item_t e;
    e.a = a; e.r = r; e.s = s; e.h = h; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic instr(input logic [15:0] pc, input logic [15:0] ea,
                       input logic st, input logic [7:0] d, input string tag);
    push(pc, 1'b1, 1'b1, 1'b0, 8'h00, {tag, " fetch R1/R4"});
    push(pc + 16'd1, 1'b1, 1'b0, 1'b0, 8'h00, {tag, " low byte R2"});
    push(pc + 16'd2, 1'b1, 1'b0, 1'b0, 8'h00, {tag, " high byte R2/R11"});
    push(ea, !st, 1'b0, 1'b0, d, {tag, st ? " store R3/R5" : " operand R3/R4"});
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] op, input logic [15:0] ea);
    mem[a[11:0]] = op;
    mem[(a + 16'd1) & 16'h0fff] = ea[7:0];
    mem[(a + 16'd2) & 16'h0fff] = ea[15:8];
  endtask

  task automatic check_mem(input logic [15:0] a, input logic [7:0] exp, input string tag);
    checks++;
    if (mem[a[11:0]] !== exp) begin
      failures++;
      $display("FAIL %s: mem[%h]=%h expected %h", tag, a, mem[a[11:0]], exp);
    end
  endtask

  task automatic run_out();
    while (q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: queue=%0d expected 0", q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    // R10 encodings: AD load, 8D store, 6D add, 2D and, 0D or, 4D xor
    put(16'h0100, 8'hAD, 16'h0200);
    put(16'h0103, 8'h8D, 16'h0210);
    put(16'h0106, 8'h6D, 16'h0201);
    put(16'h0109, 8'h6D, 16'h0202);
    put(16'h010C, 8'h8D, 16'h0211);
    put(16'h010F, 8'h2D, 16'h0203);
    put(16'h0112, 8'h0D, 16'h0204);
    put(16'h0115, 8'h4D, 16'h0205);
    put(16'h0118, 8'h8D, 16'h0212);
    put(16'h011B, 8'h8D, 16'h011F);
    put(16'h011E, 8'hAD, 16'h0200);
    put(16'h0121, 8'h8D, 16'h0213);
    mem[12'h124] = 8'h02;
    mem[12'h200] = 8'h5A; mem[12'h201] = 8'hF0; mem[12'h202] = 8'h01;
    mem[12'h203] = 8'h0F; mem[12'h204] = 8'hA0; mem[12'h205] = 8'hFF;
    mem[12'h253] = 8'h77;

    instr(16'h0100, 16'h0200, 1'b0, 8'h00, "R1 R10 load");
    instr(16'h0103, 16'h0210, 1'b1, 8'h5A, "R6 store after load");
    instr(16'h0106, 16'h0201, 1'b0, 8'h00, "R7 add carry out");
    instr(16'h0109, 16'h0202, 1'b0, 8'h00, "R7 add carry in");
    instr(16'h010C, 16'h0211, 1'b1, 8'h4C, "R7 store sum");
    instr(16'h010F, 16'h0203, 1'b0, 8'h00, "R7 and");
    instr(16'h0112, 16'h0204, 1'b0, 8'h00, "R7 or");
    instr(16'h0115, 16'h0205, 1'b0, 8'h00, "R7 xor");
    instr(16'h0118, 16'h0212, 1'b1, 8'h53, "R7 store logic");
    instr(16'h011B, 16'h011F, 1'b1, 8'h53, "R8 patch code");
    instr(16'h011E, 16'h0253, 1'b0, 8'h00, "R8 patched load");
    instr(16'h0121, 16'h0213, 1'b1, 8'h77, "R8 store patched");
    push(16'h0124, 1'b1, 1'b1, 1'b0, 8'h00, "R9 illegal fetch");
    for (int i = 0; i < 4; i++) push(16'h0124, 1'b1, 1'b0, 1'b1, 8'h00, "R9 halted");

    @(posedge clk); @(posedge clk);
    #1 rst = 1'b0;
    run_out();
    check_mem(16'h0210, 8'h5A, "R6 load then store");
    check_mem(16'h0211, 8'h4C, "R7 add chain");
    check_mem(16'h0212, 8'h53, "R7 and/or/xor");
    check_mem(16'h0213, 8'h77, "R8 fresh fetch");
    check_mem(16'h011F, 8'h53, "R5 patch written");

    // R11 wrap at top of memory, R1 restart from halt
    #1 rst = 1'b1;
    reset_vec = 16'hFFFE;
    mem[12'hFFE] = 8'hAD; mem[12'hFFF] = 8'h30; mem[12'h000] = 8'h02;
    mem[12'h230] = 8'h99;
    put(16'h0001, 8'h8D, 16'h0240);
    mem[12'h004] = 8'hFF;
    push(16'hFFFE, 1'b1, 1'b1, 1'b0, 8'h00, "R1 R11 wrap fetch");
    push(16'hFFFF, 1'b1, 1'b0, 1'b0, 8'h00, "R11 low byte");
    push(16'h0000, 1'b1, 1'b0, 1'b0, 8'h00, "R11 high byte wrapped");
    push(16'h0230, 1'b1, 1'b0, 1'b0, 8'h00, "R3 wrap operand");
    instr(16'h0001, 16'h0240, 1'b1, 8'h99, "R11 R4 pc wrapped");
    push(16'h0004, 1'b1, 1'b1, 1'b0, 8'h00, "R9 illegal FF");
    for (int i = 0; i < 3; i++) push(16'h0004, 1'b1, 1'b0, 1'b1, 8'h00, "R9 halted again");
    @(posedge clk); @(posedge clk);
    #1 rst = 1'b0;
    run_out();
    check_mem(16'h0240, 8'h99, "R11 wrap load/store");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule